// File: doc/BRIEF.md
# Accelerator Region Allocation Searcher

This block decides where an accelerator request should run. A request names a client, a device and a priority. The block looks at a compatibility map that says which devices fit in which reconfigurable region, and at a live descriptor for each region. Each descriptor holds the region's state, the device it currently holds, that task's priority and the region's size. One cycle later the block returns a solution. The solution gives a method (assign, preempt or unavailable), the chosen region and a flag that says whether the region must be reconfigured first.

Requests that find no region are kept in a pending list. In every cycle with no new request, the block scans the whole list against the current descriptors and serves one solvable entry. It picks the highest-priority entry, and among equal priorities the oldest. That solution is issued with a one-cycle interrupt pulse. The surrounding manager updates the region descriptors and performs the actual reconfiguration.

Top module: `alloc_searcher`

## Requirements
- R1: A region is a candidate only if its bit in `compat_map` is 1 for the requested device; that bit is at index region*NDEV + device.
- R2: If any compatible region is idle (state code 0), the method is assign (code 1), even when a preemptible region is smaller.
- R3: Preempt (code 2) is chosen only when no idle candidate exists. It targets only a busy region (state code 1) whose hosted priority is strictly lower than the request's. Regions in preempt (2), hold (3) or reconfig (4) state are never chosen.
- R4: Among candidates of the chosen method, the region with the smallest `rgn_size` wins. Size ties go to the lowest region index.
- R5: `sol_reconfig` is 1 exactly when the chosen region's hosted device differs from the requested device.
- R6: A request sampled with `req_valid` yields `sol_valid` on the next cycle with the request's client and device echoed. If no candidate exists, the method is unavailable (code 0) and the request enters the pending list.
- R7: The pending list holds NPEND requests. An unavailable request that arrives while the list is full pulses `req_reject` with its result, and that request is dropped.
- R8: In each cycle without `req_valid`, the block serves one pending entry that now has a solution. It picks the highest priority, and the oldest among equal priorities. The entry is removed and its solution appears on the next cycle.
- R9: `sol_irq` pulses together with `sol_valid` exactly when the solution comes from the pending list.
- R10: After reset, `sol_valid`, `sol_irq` and `req_reject` are 0 and the pending list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | New request present |
| req_client | input | CLIENT_W | Requesting client id |
| req_dev | input | DEV_W | Requested device id |
| req_prio | input | PRIO_W | Request priority, larger is more urgent |
| compat_map | input | NREG*NDEV | Device-fits-region map |
| rgn_state | input | NREG*3 | Per-region state codes |
| rgn_dev | input | NREG*DEV_W | Device held by each region |
| rgn_prio | input | NREG*PRIO_W | Priority of the task in each region |
| rgn_size | input | NREG*SIZE_W | Area of each region |
| sol_valid | output | 1 | Solution present |
| sol_method | output | 2 | 0 unavailable, 1 assign, 2 preempt |
| sol_region | output | RIDX_W | Chosen region |
| sol_reconfig | output | 1 | Region must be reloaded |
| sol_client | output | CLIENT_W | Client of the solved request |
| sol_dev | output | DEV_W | Device of the solved request |
| sol_irq | output | 1 | Solution came from the pending list |
| req_reject | output | 1 | Request dropped, list full |

## Verification
Some rules are checked on every cycle against the search result and the descriptors. An assign must land on an idle region. A preempt must hit a busy region with strictly lower hosted priority. An interrupt is never paired with an unavailable method. A reject only accompanies an unavailable result. A solvable pending entry in a quiet cycle always produces an interrupt, and the list count stays within bounds. Other behaviours need the bench's scenarios: the size ordering with its index tie-break, the reconfigure flag, the exact priority-then-age service order of the pending list, and the fact that a rejected request never comes back.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    RS_IDLE    = 3'd0,
    RS_BUSY    = 3'd1,
    RS_PREEMPT = 3'd2,
    RS_HOLD    = 3'd3,
    RS_RECFG   = 3'd4
  } rgn_state_e;

  typedef enum logic [1:0] {
    SM_UNAVAIL = 2'd0,
    SM_ASSIGN  = 2'd1,
    SM_PREEMPT = 2'd2
  } sol_method_e;
endpackage

// File: rtl/rgn_search.sv
module rgn_search
  import alloc_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int NDEV   = 8,
  parameter int PRIO_W = 3,
  parameter int SIZE_W = 8,
  parameter int DEV_W  = $clog2(NDEV),
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic [DEV_W-1:0]          q_dev,
  input  logic [PRIO_W-1:0]         q_prio,
  input  logic [NREG*NDEV-1:0]      compat,
  input  logic [NREG*STATE_W-1:0]   st_flat,
  input  logic [NREG*DEV_W-1:0]     dv_flat,
  input  logic [NREG*PRIO_W-1:0]    pr_flat,
  input  logic [NREG*SIZE_W-1:0]    sz_flat,
  output sol_method_e               method,
  output logic [RIDX_W-1:0]         region,
  output logic                      reconfig
);
  rgn_state_e        st [NREG];
  logic [DEV_W-1:0]  dv [NREG];
  logic [PRIO_W-1:0] pr [NREG];
  logic [SIZE_W-1:0] sz [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_unpack
    assign st[r] = rgn_state_e'(st_flat[r*STATE_W +: STATE_W]);
    assign dv[r] = dv_flat[r*DEV_W +: DEV_W];
    assign pr[r] = pr_flat[r*PRIO_W +: PRIO_W];
    assign sz[r] = sz_flat[r*SIZE_W +: SIZE_W];
  end

  // smaller area wins; strict compare keeps the lowest index on ties
  function automatic logic smaller(input logic have, input logic [SIZE_W-1:0] cand,
                                   input logic [SIZE_W-1:0] best);
    return !have || (cand < best);
  endfunction

  logic              idle_hit, pre_hit;
  logic [RIDX_W-1:0] idle_idx, pre_idx;
  logic [SIZE_W-1:0] idle_sz, pre_sz;

  always_comb begin
    idle_hit = 1'b0; pre_hit = 1'b0;
    idle_idx = '0;   pre_idx = '0;
    idle_sz  = '1;   pre_sz  = '1;
    for (int r = 0; r < NREG; r++) begin
      if (compat[r*NDEV + int'(q_dev)]) begin
        if (st[r] == RS_IDLE && smaller(idle_hit, sz[r], idle_sz)) begin
          idle_hit = 1'b1; idle_idx = RIDX_W'(r); idle_sz = sz[r];
        end
        if (st[r] == RS_BUSY && q_prio > pr[r] && smaller(pre_hit, sz[r], pre_sz)) begin
          pre_hit = 1'b1; pre_idx = RIDX_W'(r); pre_sz = sz[r];
        end
      end
    end
  end

  always_comb begin
    if (idle_hit) begin
      method = SM_ASSIGN;  region = idle_idx;
    end else if (pre_hit) begin
      method = SM_PREEMPT; region = pre_idx;
    end else begin
      method = SM_UNAVAIL; region = '0;
    end
    reconfig = (method != SM_UNAVAIL) && (dv[region] != q_dev);
  end
endmodule

// File: rtl/pend_list.sv
module pend_list #(
  parameter int NPEND    = 8,
  parameter int CLIENT_W = 2,
  parameter int DEV_W    = 3,
  parameter int PRIO_W   = 3,
  parameter int IDX_W    = $clog2(NPEND),
  parameter int CNT_W    = $clog2(NPEND + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [CLIENT_W-1:0]       push_client,
  input  logic [DEV_W-1:0]          push_dev,
  input  logic [PRIO_W-1:0]         push_prio,
  input  logic                      pop,
  input  logic [IDX_W-1:0]          pop_idx,
  output logic [NPEND*CLIENT_W-1:0] ent_client,
  output logic [NPEND*DEV_W-1:0]    ent_dev,
  output logic [NPEND*PRIO_W-1:0]   ent_prio,
  output logic [NPEND-1:0]          ent_valid,
  output logic                      full
);
  logic [CLIENT_W-1:0] e_cl [NPEND];
  logic [DEV_W-1:0]    e_dv [NPEND];
  logic [PRIO_W-1:0]   e_pr [NPEND];
  logic [CNT_W-1:0]    count;

  assign full = (count == CNT_W'(NPEND));

  for (genvar i = 0; i < NPEND; i++) begin : g_out
    assign ent_client[i*CLIENT_W +: CLIENT_W] = e_cl[i];
    assign ent_dev[i*DEV_W +: DEV_W]          = e_dv[i];
    assign ent_prio[i*PRIO_W +: PRIO_W]       = e_pr[i];
    assign ent_valid[i]                       = (CNT_W'(i) < count);
  end

  // entry 0 is always the oldest: removal closes the gap by shifting down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < NPEND; i++) begin
        e_cl[i] <= '0; e_dv[i] <= '0; e_pr[i] <= '0;
      end
    end else if (push && !full) begin
      e_cl[count[IDX_W-1:0]] <= push_client;
      e_dv[count[IDX_W-1:0]] <= push_dev;
      e_pr[count[IDX_W-1:0]] <= push_prio;
      count <= count + 1'b1;
    end else if (pop) begin
      for (int i = 0; i < NPEND - 1; i++) begin
        if (i >= int'(pop_idx)) begin
          e_cl[i] <= e_cl[i+1]; e_dv[i] <= e_dv[i+1]; e_pr[i] <= e_pr[i+1];
        end
      end
      count <= count - 1'b1;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NPEND));
  a_r8_pop_live: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |-> (CNT_W'(pop_idx) < count));
endmodule

// File: rtl/alloc_searcher.sv
module alloc_searcher
  import alloc_pkg::*;
#(
  parameter int NREG    = 4,
  parameter int NDEV    = 8,
  parameter int NCLIENT = 4,
  parameter int PRIO_W  = 3,
  parameter int SIZE_W  = 8,
  parameter int NPEND   = 8,
  parameter int DEV_W    = $clog2(NDEV),
  parameter int CLIENT_W = $clog2(NCLIENT),
  parameter int RIDX_W   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [CLIENT_W-1:0]      req_client,
  input  logic [DEV_W-1:0]         req_dev,
  input  logic [PRIO_W-1:0]        req_prio,
  input  logic [NREG*NDEV-1:0]     compat_map,
  input  logic [NREG*3-1:0]        rgn_state,
  input  logic [NREG*DEV_W-1:0]    rgn_dev,
  input  logic [NREG*PRIO_W-1:0]   rgn_prio,
  input  logic [NREG*SIZE_W-1:0]   rgn_size,
  output logic                     sol_valid,
  output logic [1:0]               sol_method,
  output logic [RIDX_W-1:0]        sol_region,
  output logic                     sol_reconfig,
  output logic [CLIENT_W-1:0]      sol_client,
  output logic [DEV_W-1:0]         sol_dev,
  output logic                     sol_irq,
  output logic                     req_reject
);
  localparam int PIDX_W = $clog2(NPEND);

  // search for the incoming request
  sol_method_e       in_method;
  logic [RIDX_W-1:0] in_region;
  logic              in_reconfig;

  rgn_search #(.NREG(NREG), .NDEV(NDEV), .PRIO_W(PRIO_W), .SIZE_W(SIZE_W),
               .DEV_W(DEV_W), .RIDX_W(RIDX_W)) u_in_search (
    .q_dev(req_dev), .q_prio(req_prio), .compat(compat_map),
    .st_flat(rgn_state), .dv_flat(rgn_dev), .pr_flat(rgn_prio), .sz_flat(rgn_size),
    .method(in_method), .region(in_region), .reconfig(in_reconfig));

  // pending list
  logic                      push, pop, list_full;
  logic [PIDX_W-1:0]         pick_idx;
  logic [NPEND*CLIENT_W-1:0] ent_client;
  logic [NPEND*DEV_W-1:0]    ent_dev;
  logic [NPEND*PRIO_W-1:0]   ent_prio;
  logic [NPEND-1:0]          ent_valid;

  pend_list #(.NPEND(NPEND), .CLIENT_W(CLIENT_W), .DEV_W(DEV_W), .PRIO_W(PRIO_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .push(push), .push_client(req_client),
    .push_dev(req_dev), .push_prio(req_prio), .pop(pop), .pop_idx(pick_idx),
    .ent_client(ent_client), .ent_dev(ent_dev), .ent_prio(ent_prio),
    .ent_valid(ent_valid), .full(list_full));

  // one search per pending entry, all evaluated every cycle
  sol_method_e       p_method   [NPEND];
  logic [RIDX_W-1:0] p_region   [NPEND];
  logic              p_reconfig [NPEND];
  logic [PRIO_W-1:0] p_prio     [NPEND];

  for (genvar p = 0; p < NPEND; p++) begin : g_rescan
    assign p_prio[p] = ent_prio[p*PRIO_W +: PRIO_W];
    rgn_search #(.NREG(NREG), .NDEV(NDEV), .PRIO_W(PRIO_W), .SIZE_W(SIZE_W),
                 .DEV_W(DEV_W), .RIDX_W(RIDX_W)) u_p_search (
      .q_dev(ent_dev[p*DEV_W +: DEV_W]), .q_prio(p_prio[p]), .compat(compat_map),
      .st_flat(rgn_state), .dv_flat(rgn_dev), .pr_flat(rgn_prio), .sz_flat(rgn_size),
      .method(p_method[p]), .region(p_region[p]), .reconfig(p_reconfig[p]));
  end

  // highest priority solvable entry; strict compare keeps the oldest on ties
  logic              pick_hit;
  logic [PRIO_W-1:0] pick_prio;
  always_comb begin
    pick_hit = 1'b0; pick_idx = '0; pick_prio = '0;
    for (int p = 0; p < NPEND; p++) begin
      if (ent_valid[p] && p_method[p] != SM_UNAVAIL && (!pick_hit || p_prio[p] > pick_prio)) begin
        pick_hit = 1'b1; pick_idx = PIDX_W'(p); pick_prio = p_prio[p];
      end
    end
  end

  logic in_unavail, reject_now;
  assign in_unavail = (in_method == SM_UNAVAIL);
  assign reject_now = req_valid && in_unavail && list_full;
  assign push       = req_valid && in_unavail && !list_full;
  assign pop        = !req_valid && pick_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sol_valid <= 1'b0; sol_method <= SM_UNAVAIL; sol_region <= '0;
      sol_reconfig <= 1'b0; sol_client <= '0; sol_dev <= '0;
      sol_irq <= 1'b0; req_reject <= 1'b0;
    end else if (req_valid) begin
      sol_valid <= 1'b1; sol_method <= in_method; sol_region <= in_region;
      sol_reconfig <= in_reconfig; sol_client <= req_client; sol_dev <= req_dev;
      sol_irq <= 1'b0; req_reject <= reject_now;
    end else if (pick_hit) begin
      sol_valid <= 1'b1; sol_method <= p_method[pick_idx];
      sol_region <= p_region[pick_idx]; sol_reconfig <= p_reconfig[pick_idx];
      sol_client <= ent_client[pick_idx*CLIENT_W +: CLIENT_W];
      sol_dev <= ent_dev[pick_idx*DEV_W +: DEV_W];
      sol_irq <= 1'b1; req_reject <= 1'b0;
    end else begin
      sol_valid <= 1'b0; sol_irq <= 1'b0; req_reject <= 1'b0;
    end
  end

  // descriptor views used by the checks below
  logic [2:0]        chk_st;
  logic [PRIO_W-1:0] chk_pr;
  assign chk_st = rgn_state[in_region*3 +: 3];
  assign chk_pr = rgn_prio[in_region*PRIO_W +: PRIO_W];

  a_r2_assign_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_method == SM_ASSIGN) |-> (chk_st == RS_IDLE));
  a_r3_preempt_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_method == SM_PREEMPT) |-> (chk_st == RS_BUSY && req_prio > chk_pr));
  a_r9_irq_solved: assert property (@(posedge clk) disable iff (!rst_n)
    sol_irq |-> (sol_valid && sol_method != SM_UNAVAIL));
  a_r7_reject_unavail: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (sol_valid && sol_method == SM_UNAVAIL && !sol_irq));
  a_r8_scan_serves: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && pick_hit) |=> sol_irq);
  a_r9_irq_reject_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sol_irq, req_reject}));
endmodule

// File: tb/alloc_searcher_tb.sv
`timescale 1ns/1ps
module alloc_searcher_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_client = '0;
  logic [2:0]  req_dev = '0, req_prio = '0;
  logic [31:0] compat = '0;
  logic [11:0] st = '0, dv = '0, pr = '0;
  logic [31:0] sz = '0;
  logic        sol_valid, sol_reconfig, sol_irq, req_reject;
  logic [1:0]  sol_method, sol_region, sol_client;
  logic [2:0]  sol_dev;

  alloc_searcher u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_client(req_client),
    .req_dev(req_dev), .req_prio(req_prio), .compat_map(compat), .rgn_state(st),
    .rgn_dev(dv), .rgn_prio(pr), .rgn_size(sz), .sol_valid(sol_valid),
    .sol_method(sol_method), .sol_region(sol_region), .sol_reconfig(sol_reconfig),
    .sol_client(sol_client), .sol_dev(sol_dev), .sol_irq(sol_irq), .req_reject(req_reject));

  int total = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] compat;
    logic [11:0] st;
    logic [11:0] dv;
    logic [11:0] pr;
    logic [31:0] sz;
    logic [2:0]  rdev;
    logic [2:0]  rprio;
    logic [1:0]  em;
    logic [1:0]  er;
    logic        erc;
  } vec_t;

  // region 3 is the leftmost field in every flat vector
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R4: all idle, size tie between r1 and r3 -> r1
    '{32'h08080808, {3'd0,3'd0,3'd0,3'd0}, {3'd3,3'd3,3'd3,3'd3}, 12'h0,
      {8'd20,8'd30,8'd20,8'd40}, 3'd3, 3'd1, 2'd1, 2'd1, 1'b0},
    // R1/R5: only r2 compatible, holds device 5
    '{32'h00080000, {3'd0,3'd0,3'd0,3'd0}, {3'd3,3'd5,3'd3,3'd3}, 12'h0,
      {8'd10,8'd90,8'd10,8'd10}, 3'd3, 3'd1, 2'd1, 2'd2, 1'b1},
    // R2: idle r3 beats smaller preemptible r0
    '{32'h08000008, {3'd0,3'd1,3'd1,3'd1}, {3'd3,3'd3,3'd3,3'd3}, 12'h0,
      {8'd99,8'd1,8'd1,8'd5}, 3'd3, 3'd7, 2'd1, 2'd3, 1'b0},
    // R3/R4: equal priority r0 excluded, smallest lower-priority is r2
    '{32'h08080808, {3'd3,3'd1,3'd1,3'd1}, {3'd3,3'd3,3'd3,3'd3}, {3'd0,3'd1,3'd2,3'd4},
      {8'd1,8'd30,8'd50,8'd10}, 3'd3, 3'd4, 2'd2, 2'd2, 1'b0},
    // R3/R5: preempt, reconfig and hold states skipped
    '{32'h08080808, {3'd1,3'd2,3'd4,3'd3}, {3'd6,3'd3,3'd3,3'd3}, {3'd1,3'd0,3'd0,3'd0},
      {8'd200,8'd1,8'd1,8'd1}, 3'd3, 3'd6, 2'd2, 2'd3, 1'b1},
    // R5: idle r0 holds a different device
    '{32'h08080808, {3'd0,3'd0,3'd0,3'd0}, {3'd3,3'd3,3'd3,3'd7}, 12'h0,
      {8'd40,8'd30,8'd20,8'd10}, 3'd3, 3'd0, 2'd1, 2'd0, 1'b1},
    // R1: idle r0 fits only device 4, so busy r1 is preempted
    '{32'h00000810, {3'd0,3'd0,3'd1,3'd0}, {3'd3,3'd3,3'd3,3'd3}, {3'd0,3'd0,3'd2,3'd0},
      {8'd10,8'd10,8'd10,8'd10}, 3'd3, 3'd5, 2'd2, 2'd1, 1'b0}
  };

  // drive at a falling edge, sample at the next falling edge
  task automatic send(input logic [1:0] c, input logic [2:0] d, input logic [2:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_client = c; req_dev = d; req_prio = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic all_busy();
    compat = 32'hFFFFFFFF; st = {3'd1,3'd1,3'd1,3'd1};
    pr = {3'd7,3'd7,3'd7,3'd7}; dv = {3'd2,3'd2,3'd2,3'd2};
    sz = {8'd10,8'd10,8'd10,8'd10};
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; total++;
      $display("FAIL R10 watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 sol_valid after reset", sol_valid, 0);
    chk("R10 sol_irq after reset", sol_irq, 0);
    chk("R10 req_reject after reset", req_reject, 0);

    for (int v = 0; v < NV; v++) begin
      compat = VECS[v].compat; st = VECS[v].st; dv = VECS[v].dv;
      pr = VECS[v].pr; sz = VECS[v].sz;
      send(2'(v), VECS[v].rdev, VECS[v].rprio);
      chk($sformatf("R6 vec%0d valid", v), sol_valid, 1);
      chk($sformatf("R2/R3 vec%0d method", v), sol_method, VECS[v].em);
      chk($sformatf("R4 vec%0d region", v), sol_region, VECS[v].er);
      chk($sformatf("R5 vec%0d reconfig", v), sol_reconfig, VECS[v].erc);
      chk($sformatf("R6 vec%0d client", v), sol_client, v % 4);
      chk($sformatf("R9 vec%0d no irq", v), sol_irq, 0);
    end

    // R6/R8: unavailable requests queue, then drain by priority then age
    all_busy();
    send(2'd1, 3'd2, 3'd3);
    chk("R6 unavailable method", sol_method, 0);
    chk("R6 unavailable valid", sol_valid, 1);
    send(2'd2, 3'd2, 3'd5);
    send(2'd3, 3'd2, 3'd5);
    send(2'd0, 3'd2, 3'd1);
    @(negedge clk);
    chk("R8 nothing served while unsolvable", sol_valid, 0);
    st = {3'd1,3'd1,3'd1,3'd0};
    @(negedge clk);
    chk("R9 irq on pending solution", sol_irq, 1);
    chk("R8 first served prio5 oldest", sol_client, 2);
    chk("R8 served method assign", sol_method, 1);
    chk("R8 served region", sol_region, 0);
    @(negedge clk);
    chk("R8 second served prio5 newer", sol_client, 3);
    @(negedge clk);
    chk("R8 third served prio3", sol_client, 1);
    @(negedge clk);
    chk("R8 fourth served prio1", sol_client, 0);
    chk("R9 irq on last", sol_irq, 1);
    @(negedge clk);
    chk("R8 list drained", sol_valid, 0);
    chk("R9 irq low when idle", sol_irq, 0);

    // R7: ninth unavailable request is rejected and never returns
    all_busy();
    begin
      int rej = 0;
      for (int k = 0; k < 8; k++) begin
        send(2'd0, 3'd1, 3'd0);
        rej += int'(req_reject);
      end
      chk("R7 no reject before full", rej, 0);
    end
    send(2'd3, 3'd1, 3'd0);
    chk("R7 reject when full", req_reject, 1);
    chk("R7 rejected result unavailable", sol_method, 0);
    st = {3'd1,3'd1,3'd1,3'd0};
    begin
      int served = 0, c3 = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        served += int'(sol_irq);
        if (sol_irq && sol_client == 2'd3) c3++;
      end
      chk("R7 only eight served", served, 8);
      chk("R7 rejected request dropped", c3, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule